// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block is the forward error correction front stage of an OFDM transmit chain. It takes a serial stream of scrambled data bits, runs them through a constraint-length-7 rate-1/2 convolutional code with the generator pair 133 and 171 (octal), and then deletes some of the coded bits on a fixed repeating schedule. The result is an effective coding rate of 1/2, 2/3 or 3/4. The punctured coded stream leaves one bit per clock with its own valid flag.

A frame begins with a one-cycle start pulse. The pulse zeroes the code memory and realigns the deletion schedule to the frame's first bit. After that, each cycle with the input valid flag high and the ready flag high delivers one data bit. Two coded bits can come from one input bit, but only one can leave per clock. The ready flag therefore drops whenever the two-bit output holding stage is full. As a result, a continuous feed at rate 1/2 is accepted on every other clock, while the output stays busy on every clock.

Top module: `punct_conv_enc`

## Requirements
- R1: After synchronous reset (`rst` high, active high), `outValid` is 0, the code memory is all zero and the deletion phase is at its first position.
- R2: With puncturing disabled or at rate 1/2, each accepted bit produces two output bits in this order: first the parity of the current bit and the previous six bits masked by 133 octal (bit 6 is the current bit, bit 0 the oldest), then the same parity masked by 171 octal. For a single 1 followed by zeros, the output reads 1,1,0,1,1,1,1,1,0,0,1,0,1,1.
- R3: `rateSel` = 1 with `punctEn` = 1 selects rate 2/3. Within each pair of accepted bits, the first bit yields both outputs and the second bit yields only its first (133) output. A frame of n accepted bits yields n + ceil(n/2) output bits.
- R4: `rateSel` = 2 with `punctEn` = 1 selects rate 3/4. Within each triple of accepted bits, the first bit yields both outputs, the second bit only its 133 output, and the third bit only its 171 output. A frame of n accepted bits yields n + ceil(n/3) output bits.
- R5: `punctEn` = 0 forces rate 1/2 whatever `rateSel` holds, and `rateSel` = 3 also means rate 1/2.
- R6: A `start` pulse zeroes the code memory and the deletion phase. In the `start` cycle, `inReady` is 0 and the bit presented on `inBit` is not taken.
- R7: `inReady` is 1 exactly when `start` is low and at most one coded bit is waiting. While `inReady` is low outside a `start` cycle, the next cycle carries an output bit. Every kept bit is emitted exactly once, in order.
- R8: The first kept bit of an input taken at clock edge k appears on `outBit` with `outValid` high after edge k+1, following any bit that was still waiting. The second kept bit, if any, follows one clock later.
- R9: Coded bits still waiting when `start` arrives are not discarded. They are emitted in order before the new frame's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle frame start; clears code memory and deletion phase |
| punctEn | input | 1 | 1 enables puncturing per `rateSel`; 0 forces rate 1/2 |
| rateSel | input | 2 | 0: 1/2, 1: 2/3, 2: 3/4, 3: 1/2 |
| inValid | input | 1 | Input bit present |
| inBit | input | 1 | Serial data bit |
| inReady | output | 1 | Block accepts `inBit` this cycle |
| outValid | output | 1 | `outBit` holds a coded bit |
| outBit | output | 1 | Serial punctured coded bit |

## Verification
An input is taken at the edge where both `inValid` and `inReady` are high. Its first coded bit appears after the next edge, and a second coded bit, if kept, appears one edge later. `inReady` responds combinationally to `start` and to the number of bits waiting. A behavioural model advances on each rising edge using the same sampled inputs. It keeps its pending bits in a queue and its code history in a bit list, and its expected `outValid`, `outBit` and `inReady` are compared on the following falling edge, so every compare lands in the cycle where the registered result has settled. Whole-frame output counts are compared after the holding stage has drained, and impulse patterns are collected from the output bits in the order they appear.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {
    RATE_HALF     = 2'd0,
    RATE_2_OF_3   = 2'd1,
    RATE_3_OF_4   = 2'd2,
    RATE_ALT_HALF = 2'd3
  } rateSel_e;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic take;   // input bit consumed this cycle
    logic clear;  // frame start: zero code memory
    logic keepA;  // keep the 133 output of this bit
    logic keepB;  // keep the 171 output of this bit
  } ctrlStrobes_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             punctEn,
  input  logic [1:0]       rateSel,
  input  logic             inValid,
  input  logic [LVL_W-1:0] bufLevel,
  output logic             inReady,
  output ctrlStrobes_t     ctl
);
  localparam int PH_W = 2;

  rateSel_e rateEff;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastPhase;

  always_comb begin
    if (!punctEn) rateEff = RATE_HALF;
    else          rateEff = rateSel_e'(rateSel);
  end

  always_comb begin
    unique case (rateEff)
      RATE_2_OF_3: lastPhase = PH_W'(1);
      RATE_3_OF_4: lastPhase = PH_W'(2);
      default:     lastPhase = '0;
    endcase
  end

  // room for two new bits only once the stage holds at most one
  assign inReady = !start && (bufLevel < LVL_W'(2));

  always_comb begin
    ctl.take  = inValid && inReady;
    ctl.clear = start;
    unique case (rateEff)
      RATE_2_OF_3: begin
        ctl.keepA = 1'b1;
        ctl.keepB = (phase == '0);
      end
      RATE_3_OF_4: begin
        ctl.keepA = (phase != PH_W'(2));
        ctl.keepB = (phase != PH_W'(1));
      end
      default: begin
        ctl.keepA = 1'b1;
        ctl.keepB = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || start) phase <= '0;
    else if (ctl.take) phase <= (phase >= lastPhase) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int           K     = 7,
  parameter logic [K-1:0] G_A   = 7'o133,
  parameter logic [K-1:0] G_B   = 7'o171,
  parameter int           LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inBit,
  input  ctrlStrobes_t     ctl,
  output logic [LVL_W-1:0] bufLevel,
  output logic             outValid,
  output logic             outBit
);
  localparam int MEM   = K - 1;
  localparam int NGEN  = 2;

  logic [MEM-1:0]  hist;     // hist[MEM-1] newest, hist[0] oldest
  logic [K-1:0]    win;
  logic [NGEN-1:0] coded;

  assign win = {inBit, hist};

  for (genvar g = 0; g < NGEN; g++) begin : gGen
    localparam logic [K-1:0] TAPS = (g == 0) ? G_A : G_B;
    assign coded[g] = ^(win & TAPS);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) hist <= '0;
    else if (ctl.take)    hist <= win[K-1:1];
  end

  // two-slot holding stage, slot[0] leaves first
  logic [1:0]       slot, slotN;
  logic [LVL_W-1:0] lvlN;
  logic             validN, bitN;

  always_comb begin
    slotN  = slot;
    lvlN   = bufLevel;
    validN = 1'b0;
    bitN   = 1'b0;
    if (bufLevel != '0) begin
      validN = 1'b1;
      bitN   = slot[0];
      slotN  = {1'b0, slot[1]};
      lvlN   = bufLevel - 1'b1;
    end
    // control only takes when the stage empties this cycle
    if (ctl.take) begin
      unique case ({ctl.keepA, ctl.keepB})
        2'b11: begin slotN = {coded[1], coded[0]}; lvlN = LVL_W'(2); end
        2'b10: begin slotN = {1'b0, coded[0]};     lvlN = LVL_W'(1); end
        2'b01: begin slotN = {1'b0, coded[1]};     lvlN = LVL_W'(1); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      bufLevel <= '0;
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      slot     <= slotN;
      bufLevel <= lvlN;
      outValid <= validN;
      outBit   <= bitN;
    end
  end
endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
  import pce_pkg::*;
#(
  parameter int           K   = 7,
  parameter logic [K-1:0] G_A = 7'o133,
  parameter logic [K-1:0] G_B = 7'o171
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       punctEn,
  input  logic [1:0] rateSel,
  input  logic       inValid,
  input  logic       inBit,
  output logic       inReady,
  output logic       outValid,
  output logic       outBit
);
  localparam int LVL_W = 2;

  ctrlStrobes_t     ctl;
  logic [LVL_W-1:0] bufLevel;

  pce_ctrl #(.LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .punctEn(punctEn),
    .rateSel(rateSel), .inValid(inValid), .bufLevel(bufLevel),
    .inReady(inReady), .ctl(ctl)
  );

  pce_datapath #(.K(K), .G_A(G_A), .G_B(G_B), .LVL_W(LVL_W)) uData (
    .clk(clk), .rst(rst), .inBit(inBit), .ctl(ctl),
    .bufLevel(bufLevel), .outValid(outValid), .outBit(outBit)
  );
endmodule

// File: rtl/pce_checker.sv
module pce_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic inValid,
  input logic inReady,
  input logic outValid
);
  // R1: first cycle out of reset shows no output
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);

  // R6: a start cycle never takes a bit
  assert_start_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> !inReady);

  // R7: back-pressure only while bits are waiting to leave
  assert_no_idle_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (!inReady && !start) |=> outValid);

  // R8: a taken bit shows up two edges after it is sampled
  assert_take_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> ##2 outValid);
endmodule

bind punct_conv_enc pce_checker uChk (
  .clk(clk), .rst(rst), .start(start), .inValid(inValid),
  .inReady(inReady), .outValid(outValid)
);

// File: tb/punct_conv_enc_test.sv
module punct_conv_enc_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic punctEn = 1'b1;
  logic [1:0] rateSel = 2'd0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic inReady, outValid, outBit;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  punct_conv_enc uut (
    .clk(clk), .rst(rst), .start(start), .punctEn(punctEn), .rateSel(rateSel),
    .inValid(inValid), .inBit(inBit), .inReady(inReady),
    .outValid(outValid), .outBit(outBit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  // behavioural reference
  bit mq[$];
  bit mh[$];
  int mphase = 0;
  bit expV = 0, expB = 0;
  int accCnt = 0, outCnt = 0;
  bit capOn = 0;
  bit cap[$];

  function automatic int periodOf();
    if (!punctEn || rateSel == 2'd0 || rateSel == 2'd3) return 1;
    if (rateSel == 2'd1) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    bit rdy, a, b, ka, kb;
    int per;
    if (rst) begin
      mq.delete(); mh.delete();
      for (int i = 0; i < 6; i++) mh.push_back(1'b0);
      mphase = 0; expV = 0; expB = 0;
    end else begin
      rdy = (mq.size() <= 1) && !start;
      if (mq.size() > 0) begin expV = 1; expB = mq.pop_front(); end
      else begin expV = 0; expB = 0; end
      if (start) begin
        mh.delete();
        for (int i = 0; i < 6; i++) mh.push_back(1'b0);
        mphase = 0; accCnt = 0; outCnt = 0;
      end else if (inValid && rdy) begin
        // mh[d-1] is the bit d steps back
        a = inBit ^ mh[1] ^ mh[2] ^ mh[4] ^ mh[5];
        b = inBit ^ mh[0] ^ mh[1] ^ mh[2] ^ mh[5];
        per = periodOf();
        ka = 1; kb = 1;
        if (per == 2 && mphase == 1) kb = 0;
        if (per == 3 && mphase == 1) kb = 0;
        if (per == 3 && mphase == 2) ka = 0;
        if (ka) mq.push_back(a);
        if (kb) mq.push_back(b);
        mh.push_front(inBit); void'(mh.pop_back());
        mphase = (mphase + 1) % per;
        accCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(outValid == expV, {curReq, "/R8"}, "outValid", outValid, expV);
      if (expV) chk(outBit == expB, {curReq, "/R7"}, "outBit", outBit, expB);
      chk(inReady == ((mq.size() <= 1) && !start), {curReq, "/R7"}, "inReady",
          inReady, (mq.size() <= 1) && !start);
      if (outValid) begin
        outCnt++;
        if (capOn) cap.push_back(outBit);
      end
    end
  end

  task automatic drive(input bit s, input bit v, input bit d);
    @(posedge clk); #2;
    start = s; inValid = v; inBit = d;
  endtask

  task automatic feed(input int cycles, input int density, input int onesPct);
    for (int i = 0; i < cycles; i++)
      drive(1'b0, $urandom_range(99) < density, $urandom_range(99) < onesPct);
    drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
  endtask

  task automatic runFrame(input logic [1:0] rate, input bit pen, input int cycles,
                          input int density, input string req);
    int n, exp;
    curReq = req;
    @(posedge clk); #2; rateSel = rate; punctEn = pen;
    drive(1'b1, 1'b1, 1'b1);
    feed(cycles, density, 50);
    drain();
    n = accCnt;
    if (!pen || rate == 2'd0 || rate == 2'd3) exp = 2 * n;
    else if (rate == 2'd1) exp = n + (n + 1) / 2;
    else exp = n + (n + 2) / 3;
    chk(outCnt == exp, req, "frame output count", outCnt, exp);
  endtask

  task automatic impulse(input logic [1:0] rate, input bit pen,
                         input logic [15:0] pat, input int len, input string req);
    curReq = req;
    @(posedge clk); #2; rateSel = rate; punctEn = pen;
    drive(1'b1, 1'b0, 1'b0);
    cap.delete(); capOn = 1;
    drive(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 18; i++) drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    drain();
    capOn = 0;
    for (int i = 0; i < len; i++)
      chk((cap.size() > i) && (cap[i] == pat[len-1-i]), req, "impulse bit",
          (cap.size() > i) ? int'(cap[i]) : -1, pat[len-1-i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);

    // R2: generator impulse response at rate 1/2
    impulse(2'd0, 1'b1, 16'b11011111001011, 14, "R2");
    // R3 / R4: punctured impulse responses
    impulse(2'd1, 1'b1, 16'b11011100111, 11, "R3");
    impulse(2'd2, 1'b1, 16'b1101110011, 10, "R4");
    // R5: puncturing disabled, and code 3
    impulse(2'd2, 1'b0, 16'b11011111001011, 14, "R5");
    impulse(2'd3, 1'b1, 16'b11011111001011, 14, "R5");

    // continuous and gappy frames
    runFrame(2'd0, 1'b1, 200, 100, "R2");
    runFrame(2'd1, 1'b1, 301, 100, "R3");
    runFrame(2'd2, 1'b1, 299, 100, "R4");
    runFrame(2'd1, 1'b1, 250, 40, "R3");
    runFrame(2'd2, 1'b1, 250, 30, "R4");
    runFrame(2'd2, 1'b0, 150, 70, "R5");
    runFrame(2'd3, 1'b1, 150, 70, "R5");
    runFrame(2'd0, 1'b1, 150, 20, "R8");

    // R6: memory full of ones, then a start: impulse must be clean
    runFrame(2'd0, 1'b1, 40, 100, "R6");
    curReq = "R6";
    feed(20, 100, 100);
    impulse(2'd0, 1'b1, 16'b11011111001011, 14, "R6");

    // R9: start while bits wait, with a bit offered during start
    curReq = "R9";
    for (int r = 0; r < 3; r++) begin
      @(posedge clk); #2; rateSel = 2'(r);
      for (int i = 0; i < 17 + r; i++) drive(1'b0, 1'b1, $urandom_range(1));
      drive(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 30; i++) drive(1'b0, 1'b1, $urandom_range(1));
      drive(1'b0, 1'b0, 1'b0);
      drain();
    end
    chk(mq.size() == 0 && outValid == 1'b0, "R9", "drained after restarts",
        mq.size(), 0);

    // R1: reset mid-stream returns to idle
    curReq = "R1";
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    @(posedge clk); #2; rst = 1'b1; inValid = 1'b0;
    @(posedge clk); #2; rst = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after mid reset", outValid, 0);
    impulse(2'd0, 1'b1, 16'b11011111001011, 14, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule